// File: doc/BRIEF.md
# Pause and PFC Frame Receiver

This block watches the receive byte stream of an Ethernet port and picks out MAC control frames that ask the local side to pause. Bytes arrive one per cycle with a valid qualifier, a start-of-frame marker on the first byte, an end-of-frame marker on the last byte and an error flag that is meaningful on the last byte. The frame check sequence is verified upstream; the stream still carries its four bytes, and they count toward the frame length.

A frame is acted on only when it has completed without an error flag, is at least `MIN_LEN` bytes long, is addressed to the programmed 48-bit destination address and carries the MAC control type with a recognised opcode. A per-class (priority) pause frame produces a one-cycle valid pulse for each selected and locally enabled class, together with that class's 16-bit quanta. It also reloads a per-class countdown timer whose nonzero state is reported as paused. A classic pause frame reloads a single timer that drives a transmit-stop output, but only when the stop feature is switched on. Every timer counts down once per pulse on a tick input, which the user generates once per 512 bit times. A quanta of zero clears the timer at once and so acts as a resume.

The destination address comes from two configuration inputs: a high 16-bit part and a low 32-bit part. The standard control multicast address 01-80-C2-00-00-01 is high part 0x0180 and low part 0xC2000001, and it is the value to tie when nothing else is wanted. The stop control should be driven low out of reset.

Top module: `pfc_rx_monitor`

## Requirements
- R1: After a synchronous active-low reset, `tx_stop`, `cls_dur_valid` and `cls_paused` are all zero.
- R2: A frame is acted on only if its first six bytes equal `{cfg_da_hi, cfg_da_lo}`, most significant byte first (byte 0 equals `cfg_da_hi[15:8]`).
- R3: Bytes 12-13 must be 0x8808, and bytes 14-15 must be opcode 0x0101 (per-class pause) or 0x0001 (classic pause). Any other type or opcode causes no output change.
- R4: For an accepted per-class frame, bytes 16-17 form a class vector (bit k selects class k). The quanta for class k sits in bytes 18+2k (high) and 19+2k (low). In the cycle after the end-of-frame byte is sampled, `cls_dur_valid[k]` is high for exactly one cycle for every selected and enabled class, and `cls_dur_quanta[16k+15:16k]` holds that class's quanta.
- R5: A class whose `cfg_class_en` bit is 0, or whose vector bit is 0, gets no valid pulse, and its paused state is left unchanged.
- R6: From the cycle after a class's valid pulse, `cls_paused[k]` is high while its timer is nonzero. The timer loads the quanta and decrements on each `tick`, and a load takes priority over a tick in the same cycle. A quanta of zero makes `cls_paused[k]` low.
- R7: An accepted classic pause frame carries its quanta in bytes 16-17. When `cfg_pause_stop` is 1, `tx_stop` is high from two cycles after the end-of-frame byte for that many ticks. When `cfg_pause_stop` is 0, `tx_stop` is unaffected. A classic frame never drives the class outputs.
- R8: A frame whose end-of-frame byte carries `rx_err` = 1 is discarded.
- R9: A frame shorter than `MIN_LEN` bytes (counted from the start byte to the end byte inclusive) is discarded. A frame of exactly `MIN_LEN` bytes is accepted.
- R10: Cycles with `rx_valid` low are ignored whatever the other stream inputs carry, so a frame with idle gaps is parsed as if it were contiguous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Frame bad, sampled with the last byte |
| tick | input | 1 | One pulse per 512 bit times |
| cfg_da_lo | input | 32 | Destination address, low 32 bits |
| cfg_da_hi | input | 16 | Destination address, high 16 bits |
| cfg_class_en | input | CLASSES | Per-class report enable |
| cfg_pause_stop | input | 1 | Classic pause frames stop transmission |
| tx_stop | output | 1 | Transmit stop from classic pause |
| cls_dur_valid | output | CLASSES | Per-class quanta valid pulse |
| cls_dur_quanta | output | 16*CLASSES | Per-class quanta, class k at bits 16k+15:16k |
| cls_paused | output | CLASSES | Per-class timer nonzero |

## Verification
The main function is driven with per-class frames that select all classes, a sparse vector crossed with a partial enable mask, and an all-zero quanta resume. Together these separate the vector from the enable gating and a load from a release. Frames that differ from an accepted one in a single respect (last address byte, first address byte, type, opcode, error flag, length one below the minimum) show that each filter acts on its own. A frame of exactly the minimum length, a frame with idle gaps that carry stray markers, and a reprogrammed address show the positive side of the same filters. Classic pause frames are sent with the stop control off and on, and ticks run during reception so that load and decrement meet in the same cycle.

// File: rtl/pfc_rx_pkg.sv
// Shared constants and types for the pause/PFC receive monitor.
package pfc_rx_pkg;
    localparam int          QW         = 16;
    localparam logic [15:0] CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] OP_CLASSIC = 16'h0001;
    localparam logic [15:0] OP_CLASS   = 16'h0101;
    localparam logic [47:0] DA_DEFAULT = 48'h0180_C200_0001;
    localparam int          FLD_BASE   = 12;  // byte offset of the type field
    localparam int          FLD_TYPE   = 0;
    localparam int          FLD_OP     = 1;
    localparam int          FLD_W0     = 2;   // class vector or classic quanta
    localparam int          FLD_Q0     = 3;   // first per-class quanta

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_CLASSIC = 2'd1,
        KIND_CLASS   = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/pfc_rx_parser.sv
// Byte-stream parser. Counts bytes from the start marker, compares the
// destination address on the fly, captures the 16-bit fields from byte 12
// onward, and at the end byte emits a one-cycle result when the frame is a
// well-formed control frame.
// Assumes: MIN_LEN covers the whole captured header (>= 34) and LEN_W can
// hold MIN_LEN; the counter saturates on very long frames.
module pfc_rx_parser
    import pfc_rx_pkg::*;
#(
    parameter int CLASSES = 8,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_sof,
    input  logic                  rx_eof,
    input  logic                  rx_err,
    input  logic [47:0]           cfg_da,
    output frame_kind_e           res_kind,
    output logic [CLASSES-1:0]    res_vec,
    output logic [CLASSES*QW-1:0] res_q,
    output logic [QW-1:0]         res_classic_q
);
    localparam int NFLD    = FLD_Q0 + CLASSES;
    localparam int FLD_END = FLD_BASE + 2 * NFLD;
    localparam int FI_W    = $clog2(NFLD);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic             in_frame_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] rel;
    logic [FI_W-1:0]  slot;
    logic             beat;
    logic             fld_hit;
    logic             da_pos_hit;
    logic [2:0]       da_pos;
    logic [7:0]       da_exp;
    logic             da_ok_q;
    logic [LEN_W:0]   len_now;
    logic             len_ok;
    logic             frame_ok;
    logic [15:0]      fld_q [NFLD];

    // Byte position decode for the current beat.
    always_comb begin
        beat       = rx_valid && (rx_sof || in_frame_q);
        idx        = rx_sof ? '0 : cnt_q;
        rel        = idx - LEN_W'(FLD_BASE);
        slot       = rel[FI_W:1];
        fld_hit    = (idx >= LEN_W'(FLD_BASE)) && (idx < LEN_W'(FLD_END));
        da_pos_hit = idx < LEN_W'(6);
        da_pos     = 3'd5 - idx[2:0];
        da_exp     = cfg_da[{da_pos, 3'b000} +: 8];
        len_now    = {1'b0, idx} + (LEN_W+1)'(1);
        len_ok     = len_now >= (LEN_W+1)'(MIN_LEN);
    end

    // End-of-frame acceptance decision.
    always_comb begin
        frame_ok = beat && rx_eof && !rx_err && len_ok && da_ok_q &&
                   (fld_q[FLD_TYPE] == CTRL_TYPE);
    end

    // Frame tracking and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
        end else if (beat) begin
            in_frame_q <= !rx_eof;
            cnt_q      <= (idx == CNT_MAX) ? idx : idx + LEN_W'(1);
        end
    end

    // Running destination address comparison over bytes 0..5.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            da_ok_q <= 1'b0;
        end else if (beat && da_pos_hit) begin
            da_ok_q <= (rx_sof || da_ok_q) && (rx_data == da_exp);
        end
    end

    // Capture of the big-endian 16-bit header fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFLD; i++) fld_q[i] <= '0;
        end else if (beat && fld_hit) begin
            if (!rel[0]) fld_q[slot][15:8] <= rx_data;
            else         fld_q[slot][7:0]  <= rx_data;
        end
    end

    // Result pulse and held quanta for accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_kind      <= KIND_NONE;
            res_vec       <= '0;
            res_q         <= '0;
            res_classic_q <= '0;
        end else begin
            res_kind <= KIND_NONE;
            if (frame_ok && fld_q[FLD_OP] == OP_CLASS) begin
                res_kind <= KIND_CLASS;
                res_vec  <= fld_q[FLD_W0][CLASSES-1:0];
                for (int k = 0; k < CLASSES; k++)
                    res_q[k*QW +: QW] <= fld_q[FLD_Q0 + k];
            end else if (frame_ok && fld_q[FLD_OP] == OP_CLASSIC) begin
                res_kind      <= KIND_CLASSIC;
                res_classic_q <= fld_q[FLD_W0];
            end
        end
    end
endmodule

// File: rtl/pfc_rx_timer.sv
// Pause countdown. Loads a quanta, decrements once per tick down to zero,
// and reports busy while nonzero. A load wins over a tick in the same cycle.
module pfc_rx_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         busy
);
    logic [W-1:0] cnt_q;

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= load_val;
        else if (tick && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
    end

    assign busy = cnt_q != '0;
endmodule

// File: rtl/pfc_rx_monitor.sv
// Top of the pause/PFC receive monitor. Joins the parser result with the
// per-class enables and the stop control, and keeps one countdown per class
// plus one for classic pause.
// Assumes: configuration inputs are quasi-static while frames arrive.
module pfc_rx_monitor
    import pfc_rx_pkg::*;
#(
    parameter int CLASSES = 8,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_sof,
    input  logic                  rx_eof,
    input  logic                  rx_err,
    input  logic                  tick,
    input  logic [31:0]           cfg_da_lo,
    input  logic [15:0]           cfg_da_hi,
    input  logic [CLASSES-1:0]    cfg_class_en,
    input  logic                  cfg_pause_stop,
    output logic                  tx_stop,
    output logic [CLASSES-1:0]    cls_dur_valid,
    output logic [CLASSES*QW-1:0] cls_dur_quanta,
    output logic [CLASSES-1:0]    cls_paused
);
    frame_kind_e        res_kind;
    logic [CLASSES-1:0] res_vec;
    logic [QW-1:0]      res_classic_q;
    logic               classic_load;

    pfc_rx_parser #(
        .CLASSES (CLASSES),
        .MIN_LEN (MIN_LEN),
        .LEN_W   (LEN_W)
    ) u_parser (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_sof        (rx_sof),
        .rx_eof        (rx_eof),
        .rx_err        (rx_err),
        .cfg_da        ({cfg_da_hi, cfg_da_lo}),
        .res_kind      (res_kind),
        .res_vec       (res_vec),
        .res_q         (cls_dur_quanta),
        .res_classic_q (res_classic_q)
    );

    // Per-class report gating.
    always_comb begin
        cls_dur_valid = (res_kind == KIND_CLASS) ? (res_vec & cfg_class_en) : '0;
        classic_load  = (res_kind == KIND_CLASSIC) && cfg_pause_stop;
    end

    for (genvar k = 0; k < CLASSES; k++) begin : g_cls
        pfc_rx_timer #(.W(QW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cls_dur_valid[k]),
            .load_val (cls_dur_quanta[k*QW +: QW]),
            .tick     (tick),
            .busy     (cls_paused[k])
        );
    end

    pfc_rx_timer #(.W(QW)) u_classic (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (classic_load),
        .load_val (res_classic_q),
        .tick     (tick),
        .busy     (tx_stop)
    );
endmodule

// File: rtl/pfc_rx_monitor_chk.sv
// Protocol checker for the pause/PFC receive monitor, bound to its top.
module pfc_rx_monitor_chk #(
    parameter int CLASSES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rx_valid,
    input logic                  rx_eof,
    input logic                  rx_err,
    input logic                  tick,
    input logic                  cfg_pause_stop,
    input logic                  tx_stop,
    input logic [CLASSES-1:0]    cls_dur_valid,
    input logic [CLASSES*16-1:0] cls_dur_quanta,
    input logic [CLASSES-1:0]    cls_paused
);
    logic [CLASSES-1:0] nz;
    for (genvar k = 0; k < CLASSES; k++) begin : g_nz
        assign nz[k] = cls_dur_quanta[k*16 +: 16] != 16'h0;
    end

    // R4: a valid pulse lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_dur_valid != '0) |=> (cls_dur_valid == '0));

    // R6: nonzero quanta makes the class paused next cycle
    a_r6_load_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_dur_valid != '0) |=>
        ((cls_paused & $past(cls_dur_valid & nz)) == $past(cls_dur_valid & nz)));

    // R6: zero quanta releases the class next cycle
    a_r6_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_dur_valid != '0) |=> ((cls_paused & $past(cls_dur_valid & ~nz)) == '0));

    // R5: a paused bit rises only after a pulse for that class
    a_r5_no_unsolicited_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cls_paused & ~$past(cls_paused) & ~$past(cls_dur_valid)) == '0));

    // R6: with no tick and no load the paused state holds
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cls_dur_valid == '0) |=> $stable(cls_paused));

    // R7: transmit stop rises only when the stop control is on
    a_r7_stop_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_stop) |-> $past(cfg_pause_stop));

    // R8: an errored end byte gives no pulse
    a_r8_err_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && rx_err) |=> (cls_dur_valid == '0));
endmodule

bind pfc_rx_monitor pfc_rx_monitor_chk #(.CLASSES(CLASSES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .rx_eof         (rx_eof),
    .rx_err         (rx_err),
    .tick           (tick),
    .cfg_pause_stop (cfg_pause_stop),
    .tx_stop        (tx_stop),
    .cls_dur_valid  (cls_dur_valid),
    .cls_dur_quanta (cls_dur_quanta),
    .cls_paused     (cls_paused)
);

// File: tb/tb_pfc_rx_monitor.sv
module tb_pfc_rx_monitor;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_data = 8'h00;
    logic         rx_sof = 1'b0;
    logic         rx_eof = 1'b0;
    logic         rx_err = 1'b0;
    logic         tick = 1'b0;
    logic [31:0]  cfg_da_lo = 32'hC200_0001;
    logic [15:0]  cfg_da_hi = 16'h0180;
    logic [7:0]   cfg_class_en = 8'hFF;
    logic         cfg_pause_stop = 1'b0;
    logic         tx_stop;
    logic [7:0]   cls_dur_valid;
    logic [127:0] cls_dur_quanta;
    logic [7:0]   cls_paused;

    pfc_rx_monitor dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .tick(tick),
        .cfg_da_lo(cfg_da_lo), .cfg_da_hi(cfg_da_hi), .cfg_class_en(cfg_class_en),
        .cfg_pause_stop(cfg_pause_stop), .tx_stop(tx_stop),
        .cls_dur_valid(cls_dur_valid), .cls_dur_quanta(cls_dur_quanta),
        .cls_paused(cls_paused)
    );

    always #5 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    tick_en = 1'b0;
    int    tick_cnt = 0;
    logic [15:0] qv [8];
    logic [7:0]  snap_valid;
    logic [127:0] snap_q;
    localparam logic [47:0] DA_STD = 48'h0180_C200_0001;

    // Reference model state.
    int          m_t [8];
    int          m_p;
    logic [7:0]  m_pv;
    logic [15:0] m_pq [8];
    bit          m_pp;
    logic [15:0] m_ppq;
    bit          m_in;
    logic [7:0]  m_q [$];

    // Tick source: one pulse every fourth cycle while enabled.
    always @(negedge clk) begin
        tick_cnt++;
        tick = tick_en && (tick_cnt % 4 == 0);
    end

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin m_t[k] = 0; m_pq[k] = 0; end
            m_p = 0; m_pv = 0; m_pp = 0; m_in = 0; m_q.delete();
        end else begin
            for (int k = 0; k < 8; k++) begin
                if (m_pv[k]) m_t[k] = m_pq[k];
                else if (tick && m_t[k] > 0) m_t[k]--;
            end
            if (m_pp && cfg_pause_stop) m_p = m_ppq;
            else if (tick && m_p > 0) m_p--;
            m_pv = 0; m_pp = 0;
            if (rx_valid && (rx_sof || m_in)) begin
                if (rx_sof) begin m_q.delete(); m_in = 1; end
                m_q.push_back(rx_data);
                if (rx_eof) begin
                    m_in = 0;
                    if (!rx_err && m_q.size() >= 64 &&
                        {m_q[0], m_q[1], m_q[2], m_q[3], m_q[4], m_q[5]} == {cfg_da_hi, cfg_da_lo} &&
                        {m_q[12], m_q[13]} == 16'h8808) begin
                        if ({m_q[14], m_q[15]} == 16'h0101) begin
                            m_pv = m_q[17] & cfg_class_en;
                            for (int k = 0; k < 8; k++) m_pq[k] = {m_q[18+2*k], m_q[19+2*k]};
                        end else if ({m_q[14], m_q[15]} == 16'h0001) begin
                            m_pp = 1; m_ppq = {m_q[16], m_q[17]};
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [7:0] ep;
            bit ok;
            for (int k = 0; k < 8; k++) ep[k] = m_t[k] != 0;
            ok = (cls_dur_valid === m_pv) && (cls_paused === ep) && (tx_stop === (m_p != 0));
            for (int k = 0; k < 8; k++)
                if (m_pv[k] && cls_dur_quanta[16*k +: 16] !== m_pq[k]) ok = 0;
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s cycle compare: actual valid=%h paused=%h stop=%b expected valid=%h paused=%h stop=%b",
                         cur_req, cls_dur_valid, cls_paused, tx_stop, m_pv, ep, m_p != 0);
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
        end
    endtask

    task automatic send(input logic [47:0] da, input logic [15:0] typ, input logic [15:0] op,
                        input logic [15:0] w0, input int len, input bit err, input bit gaps);
        logic [7:0] b;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                rx_valid = 0; rx_sof = 1; rx_eof = 1; rx_err = 1; rx_data = 8'hAA;
            end
            if (i < 6)        b = da[8*(5-i) +: 8];
            else if (i < 12)  b = 8'h20 + 8'(i);
            else if (i == 12) b = typ[15:8];
            else if (i == 13) b = typ[7:0];
            else if (i == 14) b = op[15:8];
            else if (i == 15) b = op[7:0];
            else if (i == 16) b = w0[15:8];
            else if (i == 17) b = w0[7:0];
            else if (i < 34)  b = (i % 2 == 0) ? qv[(i-18)/2][15:8] : qv[(i-18)/2][7:0];
            else              b = 8'h00;
            @(negedge clk);
            rx_valid = 1; rx_data = b; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_err = (i == len - 1) && err;
        end
        idle(1);
        snap_valid = cls_dur_valid;
        snap_q = cls_dur_quanta;
        idle(1);
    endtask

    task automatic drain();
        tick_en = 1; idle(120); tick_en = 0; idle(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {tx_stop, cls_dur_valid, cls_paused}, 17'h0);
        rst_n = 1;
        idle(1);
        chk("R1", {tx_stop, cls_dur_valid, cls_paused}, 17'h0);
        cmp_on = 1;

        // R4: all classes selected and enabled
        cur_req = "R4";
        for (int k = 0; k < 8; k++) qv[k] = 16'(5 + k);
        send(DA_STD, 16'h8808, 16'h0101, 16'h00FF, 64, 0, 0);
        chk("R4", snap_valid, 8'hFF);
        chk("R4", snap_q[16*3 +: 16], 16'd8);
        chk("R6", cls_paused, 8'hFF);

        // R6: zero quanta releases every class
        cur_req = "R6";
        for (int k = 0; k < 8; k++) qv[k] = 16'h0;
        send(DA_STD, 16'h8808, 16'h0101, 16'h00FF, 64, 0, 0);
        chk("R6", cls_paused, 8'h00);

        // R5: sparse vector crossed with partial enable
        cur_req = "R5";
        cfg_class_en = 8'hF0;
        for (int k = 0; k < 8; k++) qv[k] = 16'(10 + 2 * k);
        send(DA_STD, 16'h8808, 16'h0101, 16'h00A5, 64, 0, 0);
        chk("R5", snap_valid, 8'hA0);
        chk("R5", cls_paused, 8'hA0);
        cfg_class_en = 8'hFF;

        // R6: countdown with ticks, then frames received while ticking
        cur_req = "R6";
        drain();
        chk("R6", cls_paused, 8'h00);
        tick_en = 1;
        send(DA_STD, 16'h8808, 16'h0101, 16'h0033, 64, 0, 0);
        send(DA_STD, 16'h8808, 16'h0101, 16'h00CC, 64, 0, 0);
        tick_en = 0;
        drain();

        // R2: address mismatches, then a reprogrammed address
        cur_req = "R2";
        for (int k = 0; k < 8; k++) qv[k] = 16'd9;
        send(48'h0180_C200_0002, 16'h8808, 16'h0101, 16'h00FF, 64, 0, 0);
        chk("R2", snap_valid, 8'h00);
        send(48'h0080_C200_0001, 16'h8808, 16'h0101, 16'h00FF, 64, 0, 0);
        chk("R2", snap_valid, 8'h00);
        chk("R2", cls_paused, 8'h00);
        cfg_da_hi = 16'h1234; cfg_da_lo = 32'h5678_9ABC;
        send(48'h1234_5678_9ABC, 16'h8808, 16'h0101, 16'h0001, 64, 0, 0);
        chk("R2", snap_valid, 8'h01);
        send(DA_STD, 16'h8808, 16'h0101, 16'h0002, 64, 0, 0);
        chk("R2", snap_valid, 8'h00);
        cfg_da_hi = 16'h0180; cfg_da_lo = 32'hC200_0001;
        drain();

        // R3: wrong type and wrong opcode
        cur_req = "R3";
        send(DA_STD, 16'h8809, 16'h0101, 16'h00FF, 64, 0, 0);
        chk("R3", snap_valid, 8'h00);
        send(DA_STD, 16'h8808, 16'h0102, 16'h00FF, 64, 0, 0);
        chk("R3", snap_valid, 8'h00);
        chk("R3", cls_paused, 8'h00);

        // R7: classic pause with stop off, then on
        cur_req = "R7";
        cfg_pause_stop = 0;
        send(DA_STD, 16'h8808, 16'h0001, 16'd6, 64, 0, 0);
        chk("R7", {snap_valid, tx_stop}, 9'h0);
        cfg_pause_stop = 1;
        send(DA_STD, 16'h8808, 16'h0001, 16'd6, 64, 0, 0);
        chk("R7", {snap_valid, tx_stop, cls_paused}, 17'h100);
        tick_en = 1; idle(40); tick_en = 0; idle(2);
        chk("R7", tx_stop, 1'b0);

        // R8: error flag on the end byte
        cur_req = "R8";
        send(DA_STD, 16'h8808, 16'h0101, 16'h00FF, 64, 1, 0);
        chk("R8", {snap_valid, cls_paused}, 16'h0);
        send(DA_STD, 16'h8808, 16'h0001, 16'd7, 64, 1, 0);
        chk("R8", tx_stop, 1'b0);

        // R9: one byte short, then exactly the minimum
        cur_req = "R9";
        send(DA_STD, 16'h8808, 16'h0101, 16'h00FF, 63, 0, 0);
        chk("R9", snap_valid, 8'h00);
        send(DA_STD, 16'h8808, 16'h0101, 16'h0080, 64, 0, 0);
        chk("R9", snap_valid, 8'h80);
        drain();

        // R10: idle gaps carrying stray markers
        cur_req = "R10";
        for (int k = 0; k < 8; k++) qv[k] = 16'(20 + k);
        send(DA_STD, 16'h8808, 16'h0101, 16'h0011, 70, 0, 1);
        chk("R10", snap_valid, 8'h11);
        chk("R10", snap_q[16*4 +: 16], 16'd24);
        drain();

        cmp_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule